// File: doc/BRIEF.md
# Graded Power-Save Mode Controller

This block decides which clock domains of a small system are running. It has five states: normal run, a halt state that stops only the processor clock, an idle state that stops every internal clock while the clock sources keep running, and a deep stop state that also switches off the oscillator and the PLL. A fifth state, settling, is a counted wait after deep stop, so the clocks stay gated until the restarted oscillator has had time to become stable.

Halt is entered only through a one-cycle strobe from the processor. Idle and deep stop are requested by writing a 2-bit request field through a small register write port. A second register holds the settling length. A pending unmasked interrupt or a non-maskable interrupt wakes the system from any of the low-power states. The asynchronous reset returns the block to run. A configuration input selects direct-clock operation. In that mode the PLL is bypassed and deep stop gates the external clock input. The settling wait still applies in this mode.

Top module: `pwr_save_ctrl`

## Requirements
- R1: While reset is low and right after it, `status` is 0 (run) and all four clock enables are high. Reset clears the request field and sets the settling length to `STAB_RESET`.
- R2: A `halt_req` pulse seen in run moves the block to halt (`status` 1) at the next clock edge. In halt only `cpu_clk_en` is low.
- R3: A write of 01 to request bits [1:0] at address 0 while in run gives idle (`status` 2) one edge after the write edge. In idle the CPU and system clocks are off and the oscillator and PLL stay on.
- R4: A write of 10 to the same field gives deep stop (`status` 3) one edge after the write edge. In deep stop all four enables are low, so oscillator and PLL turn off in the same cycle.
- R5: Request values 00 and 11 are ignored. A request write made outside run is ignored. The request field clears itself when its state is entered, so after a wake-up the block stays in run.
- R6: `irq_req` or `nmi_req` moves the block from halt or idle to run at the next edge, with no wait. Wake requests seen in run and `halt_req` pulses seen outside run have no effect.
- R7: A wake-up in deep stop moves the block to settling (`status` 4) for N+1 cycles and then to run. N is the value written at address 1. During settling the oscillator and PLL are on and the CPU and system clocks are off.
- R8: `stab_done` is high only in the last settling cycle, when the time-base count has reached zero.
- R9: With `direct_clk` high, `pll_en` stays low. `osc_en` still drops in deep stop, and the settling wait is unchanged.
- R10: `status` takes only the values 0 run, 1 halt, 2 idle, 3 deep stop and 4 settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle halt strobe from the processor |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the request field, 1 selects the settling length |
| reg_wdata | input | REG_W | Write data |
| irq_req | input | 1 | Pending unmasked maskable interrupt |
| nmi_req | input | 1 | Non-maskable interrupt |
| direct_clk | input | 1 | Direct external clock configuration |
| cpu_clk_en | output | 1 | Processor clock enable |
| sys_clk_en | output | 1 | Peripheral and system clock enable |
| osc_en | output | 1 | Oscillator enable, or external clock pass in direct mode |
| pll_en | output | 1 | PLL enable |
| stab_done | output | 1 | Settling count has reached zero |
| status | output | 3 | Current state code |

## Verification
Each low-power state is entered by its own trigger: the strobe, request code 01, and request code 10. The wake-up comes from both the interrupt and the NMI, so a wrong mapping between state and clock domains shows up as a wrong enable pattern. Request codes 00 and 11, wake-ups seen in run, and halt strobes seen outside run separate accepted stimulus from ignored stimulus. Settling lengths 3, 0, 2 and the reset default check the N+1 cycle count and the done flag at both ends of the range. Repeating deep stop in direct-clock mode confirms that the PLL stays off while the count still applies.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [2:0] {
    PS_RUN  = 3'd0,
    PS_HALT = 3'd1,
    PS_IDLE = 3'd2,
    PS_STOP = 3'd3,
    PS_STAB = 3'd4
  } ps_state_e;

  localparam logic [1:0] REQ_NONE = 2'b00;
  localparam logic [1:0] REQ_IDLE = 2'b01;
  localparam logic [1:0] REQ_STOP = 2'b10;
  localparam logic [1:0] REQ_RSVD = 2'b11;
endpackage

// File: rtl/psc_regs.sv
module psc_regs #(
  parameter int REG_W      = 16,
  parameter int CNT_W      = 16,
  parameter int STAB_RESET = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             accept,
  input  logic             clr_req,
  output logic [1:0]       req_mode,
  output logic [CNT_W-1:0] stab_len
);
  import psc_pkg::*;

  logic [1:0] wr_code;
  logic       req_take;

  assign wr_code  = wr_data[1:0];
  // Only the two real sleep codes are stored, and only while running.
  assign req_take = wr_en && !wr_addr && accept &&
                    (wr_code == REQ_IDLE || wr_code == REQ_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_mode <= REQ_NONE;
    end else if (req_take) begin
      req_mode <= wr_code;
    end else if (clr_req) begin
      req_mode <= REQ_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stab_len <= CNT_W'(STAB_RESET);
    end else if (wr_en && wr_addr) begin
      stab_len <= wr_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/psc_tbc.sv
module psc_tbc #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             count_en,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (count_en && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/psc_fsm.sv
module psc_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                wake,
  input  logic [1:0]          req_mode,
  input  logic                cnt_zero,
  output psc_pkg::ps_state_e  state,
  output logic                load_cnt,
  output logic                clr_req
);
  import psc_pkg::*;

  ps_state_e nxt;

  always_comb begin
    nxt      = state;
    load_cnt = 1'b0;
    clr_req  = 1'b0;
    unique case (state)
      PS_RUN: begin
        if (halt_req) begin
          nxt = PS_HALT;
        end else if (req_mode == REQ_IDLE) begin
          nxt     = PS_IDLE;
          clr_req = 1'b1;
        end else if (req_mode == REQ_STOP) begin
          nxt     = PS_STOP;
          clr_req = 1'b1;
        end
      end
      PS_HALT, PS_IDLE: begin
        if (wake) nxt = PS_RUN;
      end
      PS_STOP: begin
        if (wake) begin
          nxt      = PS_STAB;
          load_cnt = 1'b1;
        end
      end
      PS_STAB: begin
        if (cnt_zero) nxt = PS_RUN;
      end
      default: nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/pwr_save_ctrl.sv
module pwr_save_ctrl #(
  parameter int REG_W      = 16,
  parameter int CNT_W      = 16,
  parameter int STAB_RESET = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             irq_req,
  input  logic             nmi_req,
  input  logic             direct_clk,
  output logic             cpu_clk_en,
  output logic             sys_clk_en,
  output logic             osc_en,
  output logic             pll_en,
  output logic             stab_done,
  output logic [2:0]       status
);
  import psc_pkg::*;

  ps_state_e        state;
  logic [1:0]       req_mode;
  logic [CNT_W-1:0] stab_len;
  logic             load_cnt;
  logic             clr_req;
  logic             cnt_zero;
  logic             in_run;

  assign in_run = (state == PS_RUN);

  psc_regs #(.REG_W(REG_W), .CNT_W(CNT_W), .STAB_RESET(STAB_RESET)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .accept   (in_run),
    .clr_req  (clr_req),
    .req_mode (req_mode),
    .stab_len (stab_len)
  );

  psc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_req (halt_req),
    .wake     (irq_req | nmi_req),
    .req_mode (req_mode),
    .cnt_zero (cnt_zero),
    .state    (state),
    .load_cnt (load_cnt),
    .clr_req  (clr_req)
  );

  psc_tbc #(.CNT_W(CNT_W)) u_tbc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_cnt),
    .load_val (stab_len),
    .count_en (state == PS_STAB),
    .cnt_zero (cnt_zero)
  );

  // Each state gates a progressively larger set of domains.
  assign cpu_clk_en = in_run;
  assign sys_clk_en = in_run || (state == PS_HALT);
  assign osc_en     = (state != PS_STOP);
  assign pll_en     = !direct_clk && (state != PS_STOP);
  assign stab_done  = (state == PS_STAB) && cnt_zero;
  assign status     = state;
endmodule

// File: rtl/pwr_save_ctrl_chk.sv
module pwr_save_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic       nmi_req,
  input logic       direct_clk,
  input logic       cpu_clk_en,
  input logic       sys_clk_en,
  input logic       osc_en,
  input logic       pll_en,
  input logic       stab_done,
  input logic [2:0] status
);
  assert_halt_gating_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd1 |-> !cpu_clk_en && sys_clk_en && osc_en);

  assert_idle_gating_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd2 |-> !cpu_clk_en && !sys_clk_en && osc_en);

  assert_stop_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd3 |-> !cpu_clk_en && !sys_clk_en && !osc_en && !pll_en);

  assert_idle_quick_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd2 && (irq_req || nmi_req)) |=> status == 3'd0);

  assert_settle_from_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd4 && $past(status) != 3'd4) |-> $past(status) == 3'd3);

  assert_settle_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status == 3'd4 |-> !cpu_clk_en && !sys_clk_en && osc_en);

  assert_done_ends_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stab_done |=> status == 3'd0);

  assert_direct_no_pll_R9: assert property (@(posedge clk) disable iff (!rst_n)
    direct_clk |-> !pll_en);

  assert_legal_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 3'd4);
endmodule

bind pwr_save_ctrl pwr_save_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req),
  .nmi_req    (nmi_req),
  .direct_clk (direct_clk),
  .cpu_clk_en (cpu_clk_en),
  .sys_clk_en (sys_clk_en),
  .osc_en     (osc_en),
  .pll_en     (pll_en),
  .stab_done  (stab_done),
  .status     (status)
);

// File: tb/pwr_save_ctrl_bench.sv
module pwr_save_ctrl_bench;
  localparam int REG_W = 16;
  localparam int STAB_DEF = 5;
  localparam logic [2:0] S_RUN = 3'd0, S_HALT = 3'd1, S_IDLE = 3'd2,
                         S_STOP = 3'd3, S_STAB = 3'd4;

  typedef struct {
    logic [2:0] st;
    logic       done;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic irq_req = 1'b0, nmi_req = 1'b0, direct_clk = 1'b0;
  logic cpu_clk_en, sys_clk_en, osc_en, pll_en, stab_done;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  pwr_save_ctrl #(.REG_W(REG_W), .CNT_W(16), .STAB_RESET(STAB_DEF)) u_pwr_save_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_req(irq_req),
    .nmi_req(nmi_req), .direct_clk(direct_clk), .cpu_clk_en(cpu_clk_en),
    .sys_clk_en(sys_clk_en), .osc_en(osc_en), .pll_en(pll_en),
    .stab_done(stab_done), .status(status)
  );

  function automatic logic [4:0] model_out(input logic [2:0] st, input logic done);
    logic cpu, sys, osc, pll;
    cpu = (st == S_RUN);
    sys = (st == S_RUN) || (st == S_HALT);
    osc = (st != S_STOP);
    pll = !direct_clk && (st != S_STOP);
    return {cpu, sys, osc, pll, done};
  endfunction

  task automatic compare(input exp_t e);
    logic [4:0] got, want;
    checks++;
    got  = {cpu_clk_en, sys_clk_en, osc_en, pll_en, stab_done};
    want = model_out(e.st, e.done);
    if (status !== e.st || got !== want) begin
      errors++;
      $display("FAIL %s: status=%0d en/done=%b expected status=%0d en/done=%b",
               e.tag, status, got, e.st, want);
    end
  endtask

  // Monitor: one expected item checked per cycle, away from the edge.
  always @(negedge clk) begin
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic cyc(input logic [2:0] st, input logic dn, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.st = st; e.done = dn; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr_reg(input logic a, input logic [REG_W-1:0] d, input string tag);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc(S_RUN, 1'b0, tag);
    reg_wr = 1'b0;
  endtask

  task automatic settle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(S_STAB, 1'b0, tag);
    cyc(S_STAB, 1'b1, "R8");
    cyc(S_RUN, 1'b0, tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    exp_t e;
    #2;
    e.st = S_RUN; e.done = 1'b0; e.tag = "R1";
    compare(e);
    @(posedge clk); @(posedge clk); #1 rst_n = 1'b1;
    cyc(S_RUN, 0, "R1"); cyc(S_RUN, 0, "R10");

    // R2 halt via strobe
    halt_req = 1'b1; cyc(S_HALT, 0, "R2");
    halt_req = 1'b0; cyc(S_HALT, 0, "R2");
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 16'h0001;
    cyc(S_HALT, 0, "R5");
    reg_wr = 1'b0;
    irq_req = 1'b1; cyc(S_RUN, 0, "R6");
    irq_req = 1'b0; cyc(S_RUN, 0, "R5"); cyc(S_RUN, 0, "R5");

    // R3 idle via request field
    wr_reg(1'b0, 16'h0001, "R3");
    cyc(S_IDLE, 0, "R3");
    halt_req = 1'b1; cyc(S_IDLE, 0, "R6");
    halt_req = 1'b0;
    nmi_req = 1'b1; cyc(S_RUN, 0, "R6");
    nmi_req = 1'b0; cyc(S_RUN, 0, "R5"); cyc(S_RUN, 0, "R5");
    irq_req = 1'b1; cyc(S_RUN, 0, "R6");
    irq_req = 1'b0; cyc(S_RUN, 0, "R6");

    // R5 ignored codes
    wr_reg(1'b0, 16'h0003, "R5");
    cyc(S_RUN, 0, "R5"); cyc(S_RUN, 0, "R5");
    wr_reg(1'b0, 16'h0000, "R5");
    cyc(S_RUN, 0, "R5");

    // R4 / R7 / R8 deep stop with length 3
    wr_reg(1'b1, 16'd3, "R7");
    wr_reg(1'b0, 16'h0002, "R4");
    cyc(S_STOP, 0, "R4"); cyc(S_STOP, 0, "R4");
    irq_req = 1'b1; cyc(S_STAB, 0, "R7");
    irq_req = 1'b0;
    settle(2, "R7");

    // length 0: one settling cycle
    wr_reg(1'b1, 16'd0, "R7");
    wr_reg(1'b0, 16'h0002, "R4");
    cyc(S_STOP, 0, "R4");
    nmi_req = 1'b1; cyc(S_STAB, 1, "R8");
    nmi_req = 1'b0; cyc(S_RUN, 0, "R7"); cyc(S_RUN, 0, "R5");

    // R9 direct clock
    direct_clk = 1'b1;
    cyc(S_RUN, 0, "R9");
    wr_reg(1'b1, 16'd2, "R9");
    wr_reg(1'b0, 16'h0002, "R9");
    cyc(S_STOP, 0, "R9");
    irq_req = 1'b1; cyc(S_STAB, 0, "R9");
    irq_req = 1'b0;
    settle(1, "R9");
    direct_clk = 1'b0;
    cyc(S_RUN, 0, "R9");

    // R1 reset clears request field and restores default length
    wr_reg(1'b0, 16'h0001, "R1");
    rst_n = 1'b0; #2 rst_n = 1'b1;
    cyc(S_RUN, 0, "R1"); cyc(S_RUN, 0, "R1");
    wr_reg(1'b0, 16'h0002, "R1");
    cyc(S_STOP, 0, "R4");
    irq_req = 1'b1; cyc(S_STAB, 0, "R1");
    irq_req = 1'b0;
    settle(STAB_DEF - 1, "R1");

    @(posedge clk); @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end
endmodule